// File: doc/BRIEF.md
# Cache Miss Type Classifier

The block follows a stream of block-number lookups and labels every access as a hit or as one of three miss kinds: cold (first touch), room (the working set did not fit) or clash (the placement rule alone caused the miss). It does this by running three tag-only models side by side on the same stream. The first is the real cache, which is direct-mapped with `SETS` sets. The second is a fully-associative store with the same number of entries and exact least-recently-used eviction. The third is a one-bit-per-block record of every block number seen since reset, which stands in for a cache that never evicts.

A lookup is offered as a valid strobe with a block number. One cycle later the block returns a response strobe with the real-cache hit flag and a two-bit kind code. Three running counters, one per miss kind, change on the same edge as the response. No data is stored and no refill timing is modelled. Only tags and replacement state are kept.

Top module: `miss_classifier`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `rsp_valid`, `rsp_hit` and `rsp_kind` are 0 and all three counters are 0. Reset also empties both tag stores and the first-touch record.
- R2: The real cache is direct-mapped. A block may only occupy set `blk mod SETS`, which is its low `log2(SETS)` bits. An access hits when that set already holds the same block.
- R3: The fully-associative reference holds `SETS` entries and allows a block in any entry. When it misses while full, it drops the entry used least recently.
- R4: A real-cache miss is coded cold when the block has not been requested since reset. A stream of distinct blocks therefore produces only cold misses, and the room and clash counters stay 0.
- R5: Kind codes are 2'b00 hit, 2'b01 cold, 2'b10 room and 2'b11 clash. A miss is checked in this order: cold if first touch, otherwise room if the associative reference also misses, otherwise clash.
- R6: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. Without a request, the response fields read 0.
- R7: Every access updates all three models. This includes moving the block to most-recently-used in the associative reference even when the real cache hits.
- R8: A hit changes no counter. A miss adds one to the counter of its own kind only, and the new value is visible in the same cycle as the response.
- R9: Each counter is `CNT_W` bits wide and stops at its all-ones value instead of wrapping.
- R10: With `SETS`=4, the stream 0,4,0,4,0,4 gives two cold misses followed by four clash misses.
- R11: With `SETS`=2, the stream 0,1,2,0,3,0 gives a room miss on the fourth access (the second 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| req_valid | input | 1 | A lookup is offered this cycle |
| req_blk | input | BLK_W | Block number of the lookup |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Real direct-mapped cache hit |
| rsp_kind | output | 2 | 00 hit, 01 cold, 10 room, 11 clash |
| cnt_cold | output | CNT_W | Saturating count of cold misses |
| cnt_room | output | CNT_W | Saturating count of room misses |
| cnt_clash | output | CNT_W | Saturating count of clash misses |

## Verification
The bench builds two instances side by side from one stimulus. One has `SETS`=4 and the other has `SETS`=2, and both use `CNT_W`=4. The four-set copy reaches the mapping thrash and exact-LRU ordering cases. The two-set copy makes room misses that look like clashes, and evictions of an LRU entry that a real hit has just refreshed, occur within a few accesses. The 4-bit counters let a short run of distinct blocks drive the cold counter into saturation, which a 32-bit counter never reaches in a bench.

// File: rtl/miss_cls_pkg.sv
package miss_cls_pkg;

  typedef enum logic [1:0] {
    KIND_HIT   = 2'b00,
    KIND_COLD  = 2'b01,
    KIND_ROOM  = 2'b10,
    KIND_CLASH = 2'b11
  } miss_kind_e;

  localparam int unsigned NUM_MISS_KINDS = 3;

endpackage

// File: rtl/dm_tag_array.sv
module dm_tag_array #(
  parameter int unsigned BLK_W = 8,
  parameter int unsigned SETS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic [BLK_W-1:0] acc_blk,
  output logic             hit_o
);

  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = BLK_W - IDX_W;

  logic [SETS-1:0]  valid_q, valid_d;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [TAG_W-1:0] tag_d [SETS];
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;

  assign idx   = acc_blk[IDX_W-1:0];
  assign tag   = acc_blk[BLK_W-1:IDX_W];
  assign hit_o = valid_q[idx] && (tag_q[idx] == tag);

  always_comb begin
    valid_d = valid_q;
    for (int s = 0; s < SETS; s++) tag_d[s] = tag_q[s];
    if (acc_en) begin
      valid_d[idx] = 1'b1;
      tag_d[idx]   = tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int s = 0; s < SETS; s++) tag_q[s] <= '0;
    end else if (acc_en) begin
      valid_q <= valid_d;
      for (int s = 0; s < SETS; s++) tag_q[s] <= tag_d[s];
    end
  end

  AST_DM_FILL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_q) >= $past($countones(valid_q))); // R2

endmodule

// File: rtl/fa_lru_store.sv
module fa_lru_store #(
  parameter int unsigned BLK_W = 8,
  parameter int unsigned SETS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic [BLK_W-1:0] acc_blk,
  output logic             hit_o
);

  localparam int unsigned IDX_W = $clog2(SETS);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(SETS - 1);

  logic [SETS-1:0]  valid_q, valid_d;
  logic [BLK_W-1:0] blk_q [SETS];
  logic [BLK_W-1:0] blk_d [SETS];
  logic [IDX_W-1:0] age_q [SETS];
  logic [IDX_W-1:0] age_d [SETS];

  logic [SETS-1:0]  hit_vec;
  logic [SETS-1:0]  oldest_vec;
  logic [IDX_W-1:0] hit_way;
  logic [IDX_W-1:0] hit_age;
  logic [IDX_W-1:0] victim;
  logic             full;

  // Lookup and victim choice
  always_comb begin
    hit_way = '0;
    victim  = '0;
    for (int w = 0; w < SETS; w++) begin
      hit_vec[w]    = valid_q[w] && (blk_q[w] == acc_blk);
      oldest_vec[w] = valid_q[w] && (age_q[w] == OLDEST);
    end
    for (int w = SETS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = IDX_W'(w);
    end
    full = &valid_q;
    if (full) begin
      for (int w = 0; w < SETS; w++) begin
        if (oldest_vec[w]) victim = IDX_W'(w);
      end
    end else begin
      for (int w = SETS - 1; w >= 0; w--) begin
        if (!valid_q[w]) victim = IDX_W'(w);
      end
    end
    hit_age = age_q[hit_way];
  end

  assign hit_o = |hit_vec;

  // Replacement state update
  always_comb begin
    valid_d = valid_q;
    for (int w = 0; w < SETS; w++) begin
      blk_d[w] = blk_q[w];
      age_d[w] = age_q[w];
    end
    if (acc_en) begin
      if (hit_o) begin
        for (int w = 0; w < SETS; w++) begin
          if (valid_q[w] && (age_q[w] < hit_age)) age_d[w] = age_q[w] + IDX_W'(1);
        end
        age_d[hit_way] = '0;
      end else begin
        for (int w = 0; w < SETS; w++) begin
          if (valid_q[w]) age_d[w] = age_q[w] + IDX_W'(1);
        end
        valid_d[victim] = 1'b1;
        blk_d[victim]   = acc_blk;
        age_d[victim]   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int w = 0; w < SETS; w++) begin
        blk_q[w] <= '0;
        age_q[w] <= '0;
      end
    end else if (acc_en) begin
      valid_q <= valid_d;
      for (int w = 0; w < SETS; w++) begin
        blk_q[w] <= blk_d[w];
        age_q[w] <= age_d[w];
      end
    end
  end

  AST_FA_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R3
  AST_FA_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !hit_o && full) |-> ($countones(oldest_vec) == 1)); // R3
  AST_FA_NEVER_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_q) >= $past($countones(valid_q))); // R3

endmodule

// File: rtl/seen_bitmap.sv
module seen_bitmap #(
  parameter int unsigned BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic [BLK_W-1:0] acc_blk,
  output logic             seen_o
);

  localparam int unsigned SPACE = 1 << BLK_W;

  logic [SPACE-1:0] bits_q, bits_d;

  assign seen_o = bits_q[acc_blk];

  always_comb begin
    bits_d = bits_q;
    if (acc_en) bits_d[acc_blk] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bits_q <= '0;
    else if (acc_en) bits_q <= bits_d;
  end

  AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bits_q) >= $past($countones(bits_q))); // R4

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step_en;

  assign step_en = inc && (cnt_q != '1);

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (step_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1) |=> (cnt_q == '1)); // R9

endmodule

// File: rtl/miss_classifier.sv
module miss_classifier
  import miss_cls_pkg::*;
#(
  parameter int unsigned BLK_W = 8,
  parameter int unsigned SETS  = 4,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [BLK_W-1:0] req_blk,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [1:0]       rsp_kind,
  output logic [CNT_W-1:0] cnt_cold,
  output logic [CNT_W-1:0] cnt_room,
  output logic [CNT_W-1:0] cnt_clash
);

  logic       dm_hit, fa_hit, seen;
  miss_kind_e kind;

  dm_tag_array #(.BLK_W(BLK_W), .SETS(SETS)) u_dm (
    .clk(clk), .rst_n(rst_n), .acc_en(req_valid), .acc_blk(req_blk), .hit_o(dm_hit)
  );

  fa_lru_store #(.BLK_W(BLK_W), .SETS(SETS)) u_fa (
    .clk(clk), .rst_n(rst_n), .acc_en(req_valid), .acc_blk(req_blk), .hit_o(fa_hit)
  );

  seen_bitmap #(.BLK_W(BLK_W)) u_seen (
    .clk(clk), .rst_n(rst_n), .acc_en(req_valid), .acc_blk(req_blk), .seen_o(seen)
  );

  // Strict priority: hit, then first touch, then reference miss, else placement
  always_comb begin
    if (dm_hit)       kind = KIND_HIT;
    else if (!seen)   kind = KIND_COLD;
    else if (!fa_hit) kind = KIND_ROOM;
    else              kind = KIND_CLASH;
  end

  logic [CNT_W-1:0] cnt_all [NUM_MISS_KINDS];

  for (genvar g = 0; g < NUM_MISS_KINDS; g++) begin : g_ctr
    logic bump;
    assign bump = req_valid && (kind == miss_kind_e'(2'(g + 1)));
    sat_counter #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .inc(bump), .cnt_o(cnt_all[g])
    );
  end

  assign cnt_cold  = cnt_all[0];
  assign cnt_room  = cnt_all[1];
  assign cnt_clash = cnt_all[2];

  logic       rsp_valid_q, rsp_valid_d;
  logic       rsp_hit_q, rsp_hit_d;
  logic [1:0] rsp_kind_q, rsp_kind_d;

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_hit_d   = req_valid && dm_hit;
    rsp_kind_d  = req_valid ? 2'(kind) : 2'(KIND_HIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_kind_q  <= 2'b00;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_hit_q   <= rsp_hit_d;
      rsp_kind_q  <= rsp_kind_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_kind  = rsp_kind_q;

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R6
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_kind == 2'b00)); // R6
  AST_HIT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_valid && rsp_kind == 2'b00)); // R5
  AST_REAL_HIT_WAS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dm_hit) |-> seen); // R4
  AST_HIT_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (cnt_cold == $past(cnt_cold) && cnt_room == $past(cnt_room)
                 && cnt_clash == $past(cnt_clash))); // R8

endmodule

// File: tb/miss_classifier_tb.sv
`timescale 1ns/1ps
module miss_classifier_tb;

  localparam int BLK_W = 8;
  localparam int CNT_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [BLK_W-1:0] req_blk = '0;

  always #2 clk = ~clk;

  logic v0, h0, v1, h1;
  logic [1:0] k0, k1;
  logic [CNT_W-1:0] c0a, c0b, c0c, c1a, c1b, c1c;

  miss_classifier #(.BLK_W(BLK_W), .SETS(4), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blk(req_blk),
    .rsp_valid(v0), .rsp_hit(h0), .rsp_kind(k0),
    .cnt_cold(c0a), .cnt_room(c0b), .cnt_clash(c0c)
  );

  miss_classifier #(.BLK_W(BLK_W), .SETS(2), .CNT_W(CNT_W)) u_dut_s2 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blk(req_blk),
    .rsp_valid(v1), .rsp_hit(h1), .rsp_kind(k1),
    .cnt_cold(c1a), .cnt_room(c1b), .cnt_clash(c1c)
  );

  int n_checks = 0;
  int n_fails  = 0;

  // Behavioural reference: per instance, set contents, an LRU queue and a seen set
  int  ways [2];
  bit  m_dv [2][8];
  int  m_db [2][8];
  int  q0 [$];
  int  q1 [$];
  bit  m_seen [2][256];
  int  e_cnt [2][3];
  int  e_valid, e_hit [2], e_kind [2];

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic lru_touch(ref int q[$], input int cap, input int b, output bit hit);
    int pos = -1;
    foreach (q[i]) if (q[i] == b) pos = i;
    hit = (pos >= 0);
    if (hit) q.delete(pos);
    else if (q.size() == cap) void'(q.pop_front());
    q.push_back(b);
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      for (int s = 0; s < 8; s++) begin m_dv[i][s] = 0; m_db[i][s] = 0; end
      for (int b = 0; b < 256; b++) m_seen[i][b] = 0;
      for (int c = 0; c < 3; c++) e_cnt[i][c] = 0;
      e_hit[i] = 0; e_kind[i] = 0;
    end
    q0.delete(); q1.delete();
    e_valid = 0;
  endtask

  task automatic model_step(input bit vld, input int b);
    e_valid = vld;
    for (int i = 0; i < 2; i++) begin
      e_hit[i] = 0; e_kind[i] = 0;
      if (vld) begin
        int  idx = b % ways[i];
        bit  dmh = m_dv[i][idx] && (m_db[i][idx] == b);
        bit  fah;
        bit  sn  = m_seen[i][b];
        if (i == 0) lru_touch(q0, ways[i], b, fah);
        else        lru_touch(q1, ways[i], b, fah);
        m_dv[i][idx] = 1; m_db[i][idx] = b; m_seen[i][b] = 1;
        e_hit[i]  = dmh;
        e_kind[i] = dmh ? 0 : (!sn ? 1 : (!fah ? 2 : 3));
        if (e_kind[i] != 0 && e_cnt[i][e_kind[i]-1] < CMAX) e_cnt[i][e_kind[i]-1]++;
      end
    end
  endtask

  function automatic int pack(input logic v, input logic h, input logic [1:0] k,
                              input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b,
                              input logic [CNT_W-1:0] c);
    return int'({v, h, k, a, b, c});
  endfunction

  function automatic int pack_exp(input int i);
    logic [CNT_W-1:0] a = CNT_W'(e_cnt[i][0]);
    logic [CNT_W-1:0] b = CNT_W'(e_cnt[i][1]);
    logic [CNT_W-1:0] c = CNT_W'(e_cnt[i][2]);
    return pack(e_valid[0], e_hit[i][0], 2'(e_kind[i]), a, b, c);
  endfunction

  // Drive at negedge, let one posedge register it, compare at the next negedge
  task automatic step(input bit vld, input int b);
    req_valid = vld;
    req_blk   = BLK_W'(b);
    model_step(vld, b);
    @(posedge clk);
    @(negedge clk);
    check("R2 R3 R5 R6 R7 R8 model compare four-set", pack(v0, h0, k0, c0a, c0b, c0c), pack_exp(0));
    check("R2 R3 R5 R6 R7 R8 model compare two-set", pack(v1, h1, k1, c1a, c1b, c1c), pack_exp(1));
  endtask

  task automatic do_reset();
    req_valid = 0;
    rst_n = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    ways[0] = 4; ways[1] = 2;
    model_reset();
    @(negedge clk);
    // R1: values during reset and just after release
    check("R1 valid in reset", v0 | v1, 0);
    check("R1 counters in reset", int'(c0a | c0b | c0c | c1a | c1b | c1c), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 outputs after release", pack(v0, h0, k0, c0a, c0b, c0c), 0);
    check("R1 outputs after release two-set", pack(v1, h1, k1, c1a, c1b, c1c), 0);

    // R10: thrash on set 0 of the four-set cache
    do_reset();
    step(1, 0); check("R10 first 0 cold", k0, 1);
    step(1, 4); check("R10 first 4 cold", k0, 1);
    for (int i = 0; i < 4; i++) begin
      step(1, (i % 2 == 0) ? 0 : 4);
      check("R10 thrash clash", k0, 3);
    end
    check("R10 clash count", c0c, 4);

    // R6: an idle cycle yields no response
    step(0, 0);
    check("R6 idle no valid", v0, 0);
    check("R6 idle kind zero", k0, 0);

    // R11: room miss disguised as a re-touch in the two-set cache
    do_reset();
    step(1, 0); step(1, 1); step(1, 2);
    step(1, 0); check("R11 second 0 is room", k1, 2);
    step(1, 3); step(1, 0);

    // R2: placement by low bits, hit on the same set
    do_reset();
    step(1, 5); step(1, 9);
    step(1, 5); check("R2 5 evicted by 9 then clash", k0, 3);
    step(1, 6);
    step(1, 5); check("R2 5 hits in its set", h0, 1);
    check("R5 hit code", k0, 0);

    // R3: least recent entry is dropped
    do_reset();
    for (int b = 0; b < 5; b++) step(1, b);
    step(1, 0); check("R3 oldest dropped gives room", k0, 2);

    // R7: a real hit refreshes LRU order
    do_reset();
    for (int b = 0; b < 4; b++) step(1, b);
    step(1, 0); check("R7 retouch hits", h0, 1);
    step(1, 4);
    step(1, 0); check("R7 refreshed entry survives, clash", k0, 3);

    // R4 and R9: distinct blocks only, counter saturates
    do_reset();
    for (int b = 0; b < 40; b++) begin
      step(1, b * 3);
      check("R4 distinct is cold", k0, 1);
    end
    check("R4 no room misses", c0b, 0);
    check("R4 no clash misses", c0c, 0);
    check("R9 cold saturates", c0a, CMAX);
    check("R9 cold saturates two-set", c1a, CMAX);

    // Mixed random stream with bubbles
    do_reset();
    for (int n = 0; n < 1500; n++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 11));
      if (n == 300) do_reset();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule